// File: doc/BRIEF.md
# Digitally Trimmed One-Second Divider

This block divides an oscillator-rate enable down to a one-second tick and trims the tick rate without any analog adjustment. The divider is split into a fine stage and a coarse stage. Fine is a free-running 2^FINE_W counter, 256 at the defaults. Coarse counts UNITS fine wraps, 128 at the defaults. A second is therefore 32768 enabled oscillator steps.

A repeating correction cycle of MIN_PER_CYC minutes, each of SEC_PER_MIN seconds, runs inside the block. A 5-bit magnitude N and a direction bit set which minutes are corrected. In each of the first 2·N minutes of a cycle, the first second is trimmed. When the direction bit is 1, that second is one fine period (256 steps) shorter and the clock gains time. When the bit is 0, the second is half a fine period (128 steps) longer and the clock loses time. The correction acts only on how the coarse stage counts fine periods. The fine counter never skips or repeats, so the test tap taken from it keeps its exact rate whatever the setting.

All pins are plain control and status levels or pulses. There is no stream interface and no back-pressure. A stop level freezes every counter.

Top module: `trim_divider`

## Requirements
- R1: With no correction active, a tick_o pulse comes once every 2^FINE_W·UNITS enabled steps (32768 at defaults). tick_o is high for exactly one clock, in the clock after the enabled step that ends the second.
- R2: Seconds are grouped into minutes of SEC_PER_MIN seconds, and minutes into cycles of MIN_PER_CYC minutes. Only second 0 of a minute with index below 2·N is corrected, so at most 62 of 64 minutes at defaults. All other seconds have the R1 length.
- R3: cal_mag and cal_pos are sampled at two points: the first enabled step after reset, and the enabled step that ends the last second of a cycle. Changes at any other time have no effect until the next sample.
- R4: With cal_pos = 1, a corrected second lasts 2^FINE_W fewer enabled steps (32512 at defaults).
- R5: With cal_pos = 0, a corrected second lasts 2^(FINE_W-1) more enabled steps (32896 at defaults). Later uncorrected seconds keep the R1 length.
- R6: With a sampled magnitude of 0, no second in that cycle is corrected.
- R7: tap_o equals bit TAP_BIT of the count of enabled steps since reset, taken modulo 2^FINE_W. This gives 512 Hz at defaults, whatever cal_mag and cal_pos are set to.
- R8: A step is enabled only when osc_en = 1 and stop = 0. A clock without an enabled step leaves tap_o unchanged, produces no tick and advances no counter.
- R9: Reset (rst_n = 0, asynchronous) clears all counters. tick_o = 0 and tap_o = 0 until the first enabled step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-clock enable per oscillator period |
| stop | input | 1 | Freezes all counters while high |
| cal_mag | input | MAG_W | Correction magnitude N |
| cal_pos | input | 1 | 1: shorten corrected seconds, 0: lengthen them |
| tick_o | output | 1 | One-clock pulse per second |
| tap_o | output | 1 | Fine-stage test tap |

## Verification
The hardest case to reach is a lengthened second. Its last fine period is cut in half, which moves the phase at which every later second ends. A fault here only shows up in the seconds that follow, at the point where a cycle boundary picks up a newly sampled magnitude. The bench runs with small minute and cycle sizes so that many complete cycles fit in the run. It loads a new magnitude and direction just before each cycle boundary and scrambles cal_mag in the middle of one cycle. It also mixes random enable gaps and stop bursts into the stimulus. A bench model predicts the length of every second and the tap level after each step.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_SHORT = 2'd1,
    CORR_LONG  = 2'd2
  } corr_e;
endpackage

// File: rtl/trim_fine_stage.sv
// Free-running fine counter. A unit event marks the end of one fine
// period, measured against a phase register that can move by half a period.
module trim_fine_stage #(
  parameter int FINE_W  = 8,
  parameter int TAP_BIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic shift,
  output logic unit_evt,
  output logic tap
);
  localparam logic [FINE_W-1:0] HALF = FINE_W'(2 ** (FINE_W - 1));

  logic [FINE_W-1:0] lo_q, ph_q, lo_nxt;

  assign lo_nxt   = lo_q + 1'b1;
  assign unit_evt = step && (lo_nxt == ph_q);
  assign tap      = lo_q[TAP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      ph_q <= '0;
    end else begin
      if (step)  lo_q <= lo_nxt;
      if (shift) ph_q <= ph_q + HALF;
    end
  end

  // R8: the tap holds while no step is enabled
  p_tap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(tap));
endmodule

// File: rtl/trim_coarse_stage.sv
// Counts fine periods up to the end of a second. The end point moves
// for shortened seconds. Lengthened seconds take an extra half period.
module trim_coarse_stage
  import trim_pkg::*;
#(
  parameter int UNITS = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  unit_evt,
  input  corr_e mode,
  output logic  sec_end,
  output logic  shift
);
  localparam int HI_W = $clog2(UNITS);

  logic [HI_W-1:0] hi_q, last;
  logic            ext_q, at_last;

  assign last    = (mode == CORR_SHORT) ? HI_W'(UNITS - 2) : HI_W'(UNITS - 1);
  assign at_last = (hi_q == last);
  assign sec_end = unit_evt && (ext_q || (at_last && mode != CORR_LONG));
  assign shift   = unit_evt && !ext_q && at_last && (mode == CORR_LONG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      ext_q <= 1'b0;
    end else if (unit_evt) begin
      if (ext_q) begin
        ext_q <= 1'b0;
        hi_q  <= '0;
      end else if (at_last) begin
        hi_q  <= '0;
        ext_q <= (mode == CORR_LONG);
      end else begin
        hi_q  <= hi_q + 1'b1;
      end
    end
  end

  // R5: the extra half period is spent with the unit counter at zero
  p_ext_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q |-> (hi_q == '0));
endmodule

// File: rtl/trim_cycle_track.sv
// Second and minute position within the correction cycle, plus the
// magnitude and direction sampled at each cycle start.
module trim_cycle_track
  import trim_pkg::*;
#(
  parameter int MAG_W       = 5,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sec_end,
  input  logic [MAG_W-1:0] mag,
  input  logic             pos,
  output corr_e            mode
);
  localparam int SEC_W = $clog2(SEC_PER_MIN);
  localparam int MIN_W = $clog2(MIN_PER_CYC);

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic [MAG_W-1:0] mag_q;
  logic             pos_q, load_pend_q;
  logic             last_sec, last_min, cyc_end;

  assign last_sec = (sec_q == SEC_W'(SEC_PER_MIN - 1));
  assign last_min = (min_q == MIN_W'(MIN_PER_CYC - 1));
  assign cyc_end  = sec_end && last_sec && last_min;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q       <= '0;
      min_q       <= '0;
      mag_q       <= '0;
      pos_q       <= 1'b0;
      load_pend_q <= 1'b1;
    end else begin
      if (step && load_pend_q) begin
        mag_q       <= mag;
        pos_q       <= pos;
        load_pend_q <= 1'b0;
      end
      if (sec_end) begin
        if (last_sec) begin
          sec_q <= '0;
          min_q <= last_min ? '0 : min_q + 1'b1;
        end else begin
          sec_q <= sec_q + 1'b1;
        end
      end
      if (cyc_end) begin
        mag_q <= mag;
        pos_q <= pos;
      end
    end
  end

  always_comb begin
    mode = CORR_NONE;
    if (sec_q == '0 && int'(min_q) < 2 * int'(mag_q))
      mode = pos_q ? CORR_SHORT : CORR_LONG;
  end

  // R3: the correction choice changes only at second boundaries
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_end && !load_pend_q) |=> $stable(mode));
  // R2: minute index stays inside the cycle
  p_min_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(min_q) < MIN_PER_CYC);
endmodule

// File: rtl/trim_divider.sv
module trim_divider
  import trim_pkg::*;
#(
  parameter int FINE_W      = 8,
  parameter int UNITS       = 128,
  parameter int TAP_BIT     = 5,
  parameter int MAG_W       = 5,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             stop,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  output logic             tick_o,
  output logic             tap_o
);
  localparam logic [31:0] LEN_NORM  = 32'((2 ** FINE_W) * UNITS);
  localparam logic [31:0] LEN_SHORT = LEN_NORM - 32'(2 ** FINE_W);
  localparam logic [31:0] LEN_LONG  = LEN_NORM + 32'(2 ** (FINE_W - 1));

  logic  step_en, unit_evt, sec_end, shift, tick_q;
  corr_e mode;

  assign step_en = osc_en & ~stop;

  trim_fine_stage #(.FINE_W(FINE_W), .TAP_BIT(TAP_BIT)) u_fine (
    .clk(clk), .rst_n(rst_n), .step(step_en), .shift(shift),
    .unit_evt(unit_evt), .tap(tap_o));

  trim_coarse_stage #(.UNITS(UNITS)) u_coarse (
    .clk(clk), .rst_n(rst_n), .unit_evt(unit_evt), .mode(mode),
    .sec_end(sec_end), .shift(shift));

  trim_cycle_track #(.MAG_W(MAG_W), .SEC_PER_MIN(SEC_PER_MIN),
    .MIN_PER_CYC(MIN_PER_CYC)) u_track (
    .clk(clk), .rst_n(rst_n), .step(step_en), .sec_end(sec_end),
    .mag(cal_mag), .pos(cal_pos), .mode(mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= sec_end;
  end
  assign tick_o = tick_q;

  // Step count since the last tick, kept for the length check only
  logic [31:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= '0;
    else if (step_en) len_q <= sec_end ? '0 : len_q + 32'd1;
  end

  // R4: every second has one of the three legal lengths
  p_sec_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_end |-> (len_q + 32'd1 == LEN_NORM || len_q + 32'd1 == LEN_SHORT ||
                 len_q + 32'd1 == LEN_LONG));
  // R1: a tick follows an enabled step
  p_tick_after_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(step_en));
endmodule

// File: tb/trim_divider_bench.sv
module trim_divider_bench;
  localparam int CLK_NS = 10;
  localparam int FW  = 4;
  localparam int UN  = 8;
  localparam int TB  = 1;
  localparam int SPM = 3;
  localparam int MPC = 8;
  localparam int NORM = (2 ** FW) * UN;

  logic       clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, stop = 1'b0;
  logic [4:0] cal_mag = 5'd0;
  logic       cal_pos = 1'b0;
  logic       tick_o, tap_o;

  trim_divider #(.FINE_W(FW), .UNITS(UN), .TAP_BIT(TB), .MAG_W(5),
    .SEC_PER_MIN(SPM), .MIN_PER_CYC(MPC)) u_trim_divider (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
    .cal_mag(cal_mag), .cal_pos(cal_pos), .tick_o(tick_o), .tap_o(tap_o));

  always #(CLK_NS / 2) clk = ~clk;

  int checks = 0, errors = 0;
  int total = 0, len = 0, sec_i = 0, min_i = 0, magq = 0, secs_done = 0;
  bit posq = 0, need_load = 1, prev_step = 0, done = 0;
  string ctx = "R1";

  function automatic int exp_len(int s, int m, int mq, bit pq);
    if (s == 0 && m < 2 * mq) return pq ? NORM - 2 ** FW : NORM + 2 ** (FW - 1);
    return NORM;
  endfunction

  function automatic string kind(int s, int m, int mq, bit pq);
    if (s == 0 && m < 2 * mq) return pq ? "R4" : "R5";
    return (mq == 0) ? "R6" : "R1";
  endfunction

  // Sample at negedge, update model, check, then drive the next inputs
  task automatic step_task(input bit en, input bit st);
    int  e;
    bit  exp_tick, exp_tap;
    @(negedge clk);
    if (prev_step) begin
      if (need_load) begin magq = cal_mag; posq = cal_pos; need_load = 0; end
      total++;
      len++;
    end
    e = exp_len(sec_i, min_i, magq, posq);
    exp_tick = prev_step && (len == e);
    if (tick_o || exp_tick) begin
      checks++;
      if (tick_o !== exp_tick) begin
        errors++;
        $display("FAIL %s (%s) tick at len %0d sec %0d min %0d: actual %0b expected %0b",
                 kind(sec_i, min_i, magq, posq), ctx, len, sec_i, min_i, tick_o, exp_tick);
      end
    end
    if (exp_tick) begin
      len = 0;
      secs_done++;
      sec_i++;
      if (sec_i == SPM) begin
        sec_i = 0;
        min_i++;
        if (min_i == MPC) begin min_i = 0; magq = cal_mag; posq = cal_pos; end
      end
    end
    exp_tap = ((total % (2 ** FW)) >> TB) & 1;
    checks++;
    if (tap_o !== exp_tap) begin
      errors++;
      $display("FAIL R7 tap after %0d steps: actual %0b expected %0b", total, tap_o, exp_tap);
    end
    osc_en    = en;
    stop      = st;
    prev_step = en && !st;
  endtask

  int en_pct = 80, stop_pct = 0;
  task automatic rand_step();
    step_task(($urandom % 100) < en_pct, ($urandom % 100) < stop_pct);
  endtask

  task automatic run_seconds(input int n);
    int target = secs_done + n;
    while (secs_done < target) rand_step();
  endtask

  // Run the rest of the current cycle, loading values for the next one
  task automatic run_cycle(input int m, input bit p, input bit scramble);
    for (int k = 0; k < SPM * MPC - 1; k++) begin
      if (scramble) begin cal_mag = 5'($urandom); cal_pos = 1'($urandom); end
      run_seconds(1);
    end
    cal_mag = 5'(m);
    cal_pos = p;
    run_seconds(1);
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;   // R9 reset state
    if (tick_o !== 1'b0 || tap_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset outputs: actual %0b%0b expected 00", tick_o, tap_o);
    end
    // cycle 0: magnitude 0
    ctx = "R6";
    run_cycle(1, 1'b1, 1'b0);
    // cycle 1: N=1 shorten, inputs scrambled mid-cycle
    ctx = "R3";
    run_cycle(3, 1'b0, 1'b1);
    // cycle 2: N=3 lengthen; then directed stop window
    ctx = "R5";
    run_seconds(2);
    begin
      logic tap_hold = tap_o;
      for (int k = 0; k < 40; k++) begin
        step_task(1'b1, 1'b1);
        checks++;
        if (tick_o !== 1'b0 || tap_o !== tap_hold) begin
          errors++;
          $display("FAIL R8 stop window: actual tick %0b tap %0b expected tick 0 tap %0b",
                   tick_o, tap_o, tap_hold);
        end
      end
    end
    begin
      int rest = SPM * MPC - 2;
      for (int k = 0; k < rest - 1; k++) run_seconds(1);
      cal_mag = 5'd31; cal_pos = 1'b1;
      run_seconds(1);
    end
    // cycle 3: magnitude saturates every minute, shorten
    ctx = "R2";
    run_cycle(31, 1'b0, 1'b0);
    // cycle 4: saturated, lengthen, sparse enables with stop bursts
    en_pct = 40; stop_pct = 10;
    run_cycle(2, 1'b0, 1'b0);
    // random cycles
    ctx = "R1";
    en_pct = 90; stop_pct = 3;
    for (int c = 0; c < 2; c++) run_cycle(int'($urandom % 6), 1'($urandom), 1'b0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule